// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the register file behind the control plane of a gigabit Ethernet MAC. A host issues single-cycle read or write requests. Each request carries a byte address, a transfer size in bytes and 32 bits of write data. Exactly one clock later the block returns a response with read data and an error indication. It holds the control, status, EEPROM control, EEPROM read, interrupt cause, interrupt mask clear, receive control, transmit control, buffer allocation and management control registers. Each has a fixed reset value. Register offsets are parameters, and the field positions inside the control and EEPROM control registers are package constants.

Two registers compute part of their contents when written. The buffer allocation register splits a 64-unit packet buffer between receive and transmit. The EEPROM control register grants EEPROM access in the same write that requests it. The serial clock, data in, request and grant fields of the EEPROM control register drive output pins to a separate serial EEPROM responder, and that responder's data-out bit feeds back into reads. Some addresses belong to the filter tables, which live elsewhere; accesses to them complete quietly. Any other unrecognised address, and any access that is not 32 bits wide, is reported as an error and latched in a sticky flag.

Top module: `nic_regbank`

## Requirements
- R1: After reset, reads return 0x00000A09 for control (full duplex bit 0, link reset bit 3, speed field bits 9:8 = 2, force speed bit 11). EEPROM control returns 0x00002010 (write enable field bits 5:4 = 1, type bit 13 = 1) while the EEPROM data-out input is 0. Buffer allocation returns 0x00100030, and every other register returns zero.
- R2: Only accesses with req_bytes equal to 4 are valid. For any other size the response has rsp_err = 1 and read data 0, and no register changes.
- R3: Control, status, EEPROM read, interrupt cause, interrupt mask clear, receive control, transmit control and management control store all 32 written bits and return them on a read.
- R4: A write to buffer allocation stores wdata[15:0] as the receive share in bits 15:0. The transmit share in bits 31:16 becomes (64 − receive share) modulo 2^16.
- R5: A write to EEPROM control stores the word with the grant bit (bit 7) set equal to the written request bit (bit 6). The ee_clk, ee_din, ee_req and ee_gnt outputs follow bits 0, 2, 6 and 7 of the stored register.
- R6: Bit 3 of an EEPROM control read is the live ee_dout input. Writing bit 3 has no effect.
- R7: The wake-up control and LED control addresses read as zero without error, and writes to them are discarded.
- R8: Accesses inside the multicast table (0x5200, 128 words), receive address table (0x5400, 32 words) and VLAN filter table (0x5600, 128 words) complete without error, read zero and store nothing.
- R9: Any other address gives rsp_err = 1 and leaves all registers unchanged. err_sticky rises with the first error response and stays high until reset.
- R10: rsp_valid is high exactly in the cycle after each cycle with req_valid high, including back-to-back requests. Writes respond with read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Response is an error |
| err_sticky | output | 1 | Latched error flag |
| ee_clk | output | 1 | EEPROM serial clock field |
| ee_din | output | 1 | EEPROM serial data-in field |
| ee_dout | input | 1 | EEPROM serial data-out from responder |
| ee_req | output | 1 | EEPROM access request field |
| ee_gnt | output | 1 | EEPROM access grant field |

## Verification
Plain registers are written with dissimilar full-width patterns. This separates a correct store from a dropped, swapped or truncated word. Buffer allocation is written with a receive share below 64, equal to 64 and above 64, which exposes any error in the complement or its modulo wrap. EEPROM control is written with request alone, with grant alone and with the data-out bit set, while the data-out input is toggled. These writes show that grant follows request and that data-out comes from the pin. Table, null and unknown addresses, including the first word past a table, are mixed with undersized accesses. This separates the quiet paths from the error path and shows that the sticky flag holds.

// File: rtl/nic_regbank_pkg.sv
// Shared constants and types for the MAC control register bank.
// Field positions here are also used by the serial EEPROM responder.
package nic_regbank_pkg;

    localparam int DATA_W = 32;

    // Control register fields
    localparam int CTL_FDX_BIT  = 0;
    localparam int CTL_LRST_BIT = 3;
    localparam int CTL_SPD_LSB  = 8;
    localparam int CTL_SPD_W    = 2;
    localparam int CTL_FSPD_BIT = 11;

    // EEPROM control register fields
    localparam int EEC_CLK_BIT  = 0;
    localparam int EEC_CS_BIT   = 1;
    localparam int EEC_DIN_BIT  = 2;
    localparam int EEC_DOUT_BIT = 3;
    localparam int EEC_WEN_LSB  = 4;
    localparam int EEC_WEN_W    = 2;
    localparam int EEC_REQ_BIT  = 6;
    localparam int EEC_GNT_BIT  = 7;
    localparam int EEC_TYPE_BIT = 13;

    // Buffer allocation
    localparam int PBA_FLD_W  = 16;
    localparam int PBA_TOTAL  = 64;
    localparam int PBA_RX_RST = 'h30;

    // Plain storage registers, by index
    localparam int NUM_PLAIN  = 8;
    localparam int PLAIN_IW   = $clog2(NUM_PLAIN);
    localparam int PL_CTRL    = 0;
    localparam int PL_STATUS  = 1;
    localparam int PL_EERD    = 2;
    localparam int PL_ICR     = 3;
    localparam int PL_IMC     = 4;
    localparam int PL_RCTL    = 5;
    localparam int PL_TCTL    = 6;
    localparam int PL_MANC    = 7;

    typedef enum logic [2:0] {
        HIT_PLAIN,
        HIT_EECD,
        HIT_PBA,
        HIT_NULL,
        HIT_TABLE,
        HIT_MISS
    } hit_kind_e;

    typedef struct packed {
        hit_kind_e             kind;
        logic [PLAIN_IW-1:0]   idx;
    } decode_t;

    // Reset word of the control register built from its field constants.
    function automatic logic [DATA_W-1:0] ctrl_reset_word();
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTL_FDX_BIT]                  = 1'b1;
        v[CTL_LRST_BIT]                 = 1'b1;
        v[CTL_SPD_LSB +: CTL_SPD_W]     = 2'd2;
        v[CTL_FSPD_BIT]                 = 1'b1;
        return v;
    endfunction

    // Reset word of the EEPROM control register.
    function automatic logic [DATA_W-1:0] eecd_reset_word();
        logic [DATA_W-1:0] v;
        v = '0;
        v[EEC_WEN_LSB +: EEC_WEN_W] = 2'd1;
        v[EEC_TYPE_BIT]             = 1'b1;
        return v;
    endfunction

    // Packed reset vector for all plain registers; index 0 in the low word.
    function automatic logic [NUM_PLAIN*DATA_W-1:0] plain_reset_vec();
        logic [NUM_PLAIN*DATA_W-1:0] v;
        v = '0;
        v[PL_CTRL*DATA_W +: DATA_W] = ctrl_reset_word();
        return v;
    endfunction

endpackage

// File: rtl/nic_addr_decode.sv
// Address decoder for the register bank.
// Maps a byte address to a register class and plain-register index.
// Assumes all offsets are word aligned and that table ranges do not overlap registers.
module nic_addr_decode
    import nic_regbank_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int unsigned OFS_CTRL   = 'h0000,
    parameter int unsigned OFS_STATUS = 'h0008,
    parameter int unsigned OFS_EECD   = 'h0010,
    parameter int unsigned OFS_EERD   = 'h0014,
    parameter int unsigned OFS_ICR    = 'h00C0,
    parameter int unsigned OFS_IMC    = 'h00D8,
    parameter int unsigned OFS_RCTL   = 'h0100,
    parameter int unsigned OFS_TCTL   = 'h0400,
    parameter int unsigned OFS_PBA    = 'h1000,
    parameter int unsigned OFS_LED    = 'h0E00,
    parameter int unsigned OFS_WUC    = 'h5800,
    parameter int unsigned OFS_MANC   = 'h5820,
    parameter int unsigned MCT_BASE   = 'h5200,
    parameter int unsigned MCT_WORDS  = 128,
    parameter int unsigned RXA_BASE   = 'h5400,
    parameter int unsigned RXA_WORDS  = 32,
    parameter int unsigned VLF_BASE   = 'h5600,
    parameter int unsigned VLF_WORDS  = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    localparam int unsigned MCT_END = MCT_BASE + 4 * MCT_WORDS;
    localparam int unsigned RXA_END = RXA_BASE + 4 * RXA_WORDS;
    localparam int unsigned VLF_END = VLF_BASE + 4 * VLF_WORDS;

    logic [31:0] a32;
    logic        in_table;

    // Widen the address once for all comparisons.
    always_comb a32 = 32'(addr);

    // Flag addresses that fall in any of the externally held tables.
    always_comb begin
        in_table = ((a32 >= MCT_BASE) && (a32 < MCT_END)) ||
                   ((a32 >= RXA_BASE) && (a32 < RXA_END)) ||
                   ((a32 >= VLF_BASE) && (a32 < VLF_END));
    end

    // Classify the address.
    always_comb begin
        dec.kind = HIT_MISS;
        dec.idx  = '0;
        if      (a32 == OFS_CTRL)   begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_CTRL);   end
        else if (a32 == OFS_STATUS) begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_STATUS); end
        else if (a32 == OFS_EERD)   begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_EERD);   end
        else if (a32 == OFS_ICR)    begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_ICR);    end
        else if (a32 == OFS_IMC)    begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_IMC);    end
        else if (a32 == OFS_RCTL)   begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_RCTL);   end
        else if (a32 == OFS_TCTL)   begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_TCTL);   end
        else if (a32 == OFS_MANC)   begin dec.kind = HIT_PLAIN; dec.idx = PLAIN_IW'(PL_MANC);   end
        else if (a32 == OFS_EECD)   dec.kind = HIT_EECD;
        else if (a32 == OFS_PBA)    dec.kind = HIT_PBA;
        else if ((a32 == OFS_WUC) || (a32 == OFS_LED)) dec.kind = HIT_NULL;
        else if (in_table)          dec.kind = HIT_TABLE;
    end

endmodule

// File: rtl/nic_plain_regs.sv
// Bank of plain 32-bit storage registers with per-register reset values.
// Assumes at most one write enable is active per cycle.
module nic_plain_regs
    import nic_regbank_pkg::*;
#(
    parameter int                     NUM     = NUM_PLAIN,
    parameter logic [NUM*DATA_W-1:0]  RST_VEC = plain_reset_vec()
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM-1:0]                we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM-1:0][DATA_W-1:0]    q
);

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        // Hold one register, loading its reset word or the write data.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[g] <= RST_VEC[g*DATA_W +: DATA_W];
            else if (we[g]) q[g] <= wdata;
        end
    end

endmodule

// File: rtl/nic_eecd_reg.sv
// EEPROM control register: grant follows request on every write,
// data-out is taken live from the responder on reads.
module nic_eecd_reg
    import nic_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dout_in,
    output logic [DATA_W-1:0] rd_val,
    output logic              clk_o,
    output logic              din_o,
    output logic              req_o,
    output logic              gnt_o
);

    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] next_w;

    // Form the stored word: grant copies request, data-out bit not stored.
    always_comb begin
        next_w               = wdata;
        next_w[EEC_GNT_BIT]  = wdata[EEC_REQ_BIT];
        next_w[EEC_DOUT_BIT] = 1'b0;
    end

    // Hold the register.
    always_ff @(posedge clk) begin
        if (!rst_n)  r <= eecd_reset_word();
        else if (we) r <= next_w;
    end

    // Read value with the live data-out bit inserted.
    always_comb begin
        rd_val               = r;
        rd_val[EEC_DOUT_BIT] = dout_in;
    end

    // Drive the serial interface fields.
    always_comb begin
        clk_o = r[EEC_CLK_BIT];
        din_o = r[EEC_DIN_BIT];
        req_o = r[EEC_REQ_BIT];
        gnt_o = r[EEC_GNT_BIT];
    end

endmodule

// File: rtl/nic_pba_reg.sv
// Buffer allocation register: receive share written, transmit share derived.
module nic_pba_reg
    import nic_regbank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PBA_FLD_W-1:0]  rx_in,
    output logic [DATA_W-1:0]     rd_val
);

    logic [PBA_FLD_W-1:0] rx_q;
    logic [PBA_FLD_W-1:0] tx_q;

    // Store the receive share and its complement within the buffer total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= PBA_FLD_W'(PBA_RX_RST);
            tx_q <= PBA_FLD_W'(PBA_TOTAL - PBA_RX_RST);
        end else if (we) begin
            rx_q <= rx_in;
            tx_q <= PBA_FLD_W'(PBA_TOTAL) - rx_in;
        end
    end

    // Pack both shares into the read word.
    always_comb rd_val = DATA_W'({tx_q, rx_q});

endmodule

// File: rtl/nic_regbank.sv
// Top of the MAC control register bank.
// Accepts one request per cycle and answers it one cycle later; only
// 32-bit accesses are legal. Assumes requests are never stalled.
module nic_regbank
    import nic_regbank_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int unsigned OFS_CTRL   = 'h0000,
    parameter int unsigned OFS_STATUS = 'h0008,
    parameter int unsigned OFS_EECD   = 'h0010,
    parameter int unsigned OFS_EERD   = 'h0014,
    parameter int unsigned OFS_ICR    = 'h00C0,
    parameter int unsigned OFS_IMC    = 'h00D8,
    parameter int unsigned OFS_RCTL   = 'h0100,
    parameter int unsigned OFS_TCTL   = 'h0400,
    parameter int unsigned OFS_PBA    = 'h1000,
    parameter int unsigned OFS_LED    = 'h0E00,
    parameter int unsigned OFS_WUC    = 'h5800,
    parameter int unsigned OFS_MANC   = 'h5820,
    parameter int unsigned MCT_BASE   = 'h5200,
    parameter int unsigned MCT_WORDS  = 128,
    parameter int unsigned RXA_BASE   = 'h5400,
    parameter int unsigned RXA_WORDS  = 32,
    parameter int unsigned VLF_BASE   = 'h5600,
    parameter int unsigned VLF_WORDS  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_bytes,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              err_sticky,
    output logic              ee_clk,
    output logic              ee_din,
    input  logic              ee_dout,
    output logic              ee_req,
    output logic              ee_gnt
);

    localparam logic [2:0] WORD_BYTES = 3'd4;

    decode_t                           dec;
    logic                              size_ok;
    logic                              acc_err;
    logic                              wr_ok;
    logic [NUM_PLAIN-1:0]              plain_we;
    logic [NUM_PLAIN-1:0][DATA_W-1:0]  plain_q;
    logic [DATA_W-1:0]                 eecd_val;
    logic [DATA_W-1:0]                 pba_val;
    logic [DATA_W-1:0]                 rd_mux;

    nic_addr_decode #(
        .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL), .OFS_STATUS(OFS_STATUS),
        .OFS_EECD(OFS_EECD), .OFS_EERD(OFS_EERD), .OFS_ICR(OFS_ICR),
        .OFS_IMC(OFS_IMC), .OFS_RCTL(OFS_RCTL), .OFS_TCTL(OFS_TCTL),
        .OFS_PBA(OFS_PBA), .OFS_LED(OFS_LED), .OFS_WUC(OFS_WUC),
        .OFS_MANC(OFS_MANC), .MCT_BASE(MCT_BASE), .MCT_WORDS(MCT_WORDS),
        .RXA_BASE(RXA_BASE), .RXA_WORDS(RXA_WORDS),
        .VLF_BASE(VLF_BASE), .VLF_WORDS(VLF_WORDS)
    ) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    // Qualify the request: size check, error and write permission.
    always_comb begin
        size_ok = (req_bytes == WORD_BYTES);
        acc_err = req_valid && (!size_ok || (dec.kind == HIT_MISS));
        wr_ok   = req_valid && req_write && !acc_err;
    end

    // One write enable per plain register.
    always_comb begin
        for (int i = 0; i < NUM_PLAIN; i++) begin
            plain_we[i] = wr_ok && (dec.kind == HIT_PLAIN) &&
                          (dec.idx == PLAIN_IW'(i));
        end
    end

    nic_plain_regs #(
        .NUM     (NUM_PLAIN),
        .RST_VEC (plain_reset_vec())
    ) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (plain_we),
        .wdata (req_wdata),
        .q     (plain_q)
    );

    nic_eecd_reg u_eecd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok && (dec.kind == HIT_EECD)),
        .wdata   (req_wdata),
        .dout_in (ee_dout),
        .rd_val  (eecd_val),
        .clk_o   (ee_clk),
        .din_o   (ee_din),
        .req_o   (ee_req),
        .gnt_o   (ee_gnt)
    );

    nic_pba_reg u_pba (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_ok && (dec.kind == HIT_PBA)),
        .rx_in  (req_wdata[PBA_FLD_W-1:0]),
        .rd_val (pba_val)
    );

    // Select read data; writes and errors return zero.
    always_comb begin
        rd_mux = '0;
        if (!req_write && !acc_err) begin
            unique case (dec.kind)
                HIT_PLAIN: rd_mux = plain_q[dec.idx];
                HIT_EECD:  rd_mux = eecd_val;
                HIT_PBA:   rd_mux = pba_val;
                default:   rd_mux = '0;
            endcase
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_mux : '0;
            rsp_err   <= acc_err;
        end
    end

    // Latch any error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_sticky <= 1'b0;
        else if (acc_err) err_sticky <= 1'b1;
    end

endmodule

// File: rtl/nic_regbank_chk.sv
// Property checker for the register bank, bound into every instance.
module nic_regbank_chk #(
    parameter int          ADDR_W  = 17,
    parameter int unsigned OFS_PBA = 'h1000,
    parameter int unsigned OFS_WUC = 'h5800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_bytes,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              err_sticky,
    input logic              ee_req,
    input logic              ee_gnt
);

    // R10: a request is answered in the next cycle
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: no response without a request
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: wrong size yields an error
    a_r2_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bytes != 3'd4) |=> rsp_err);

    // R9: sticky flag never falls while out of reset
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R9: an error response is always reflected in the sticky flag
    a_r9_err_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> err_sticky);

    // R5: grant mirrors request
    a_r5_gnt_mirrors_req: assert property (@(posedge clk) disable iff (!rst_n)
        ee_gnt == ee_req);

    // R4: buffer shares always sum to the buffer total
    a_r4_pba_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_bytes == 3'd4 &&
         32'(req_addr) == OFS_PBA)
        |=> (rsp_rdata[31:16] == 16'(16'd64 - rsp_rdata[15:0])));

    // R7: wake-up control reads zero
    a_r7_wuc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && 32'(req_addr) == OFS_WUC)
        |=> (rsp_rdata == 32'h0));

endmodule

bind nic_regbank nic_regbank_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_PBA (OFS_PBA),
    .OFS_WUC (OFS_WUC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_bytes  (req_bytes),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .err_sticky (err_sticky),
    .ee_req     (ee_req),
    .ee_gnt     (ee_gnt)
);

// File: tb/tb_nic_regbank.sv
// Scoreboard bench: driver pushes expected responses, monitor compares.
module tb_nic_regbank;

    localparam int ADDR_W = 17;
    localparam logic [16:0] A_CTRL = 17'h00000, A_STATUS = 17'h00008,
        A_EECD = 17'h00010, A_EERD = 17'h00014, A_ICR = 17'h000C0,
        A_IMC = 17'h000D8, A_RCTL = 17'h00100, A_TCTL = 17'h00400,
        A_PBA = 17'h01000, A_LED = 17'h00E00, A_WUC = 17'h05800,
        A_MANC = 17'h05820;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_bytes = 3'd4;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err, err_sticky;
    logic [31:0]       rsp_rdata;
    logic              ee_clk, ee_din, ee_req, ee_gnt;
    logic              ee_dout = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    nic_regbank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .err_sticky(err_sticky), .ee_clk(ee_clk), .ee_din(ee_din),
        .ee_dout(ee_dout), .ee_req(ee_req), .ee_gnt(ee_gnt)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (q_data.size() == 0) begin
                check("R10 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] ed;
                logic        ee;
                string       t;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                t  = q_tag.pop_front();
                check({t, " data"}, rsp_rdata, ed);
                check({t, " err"}, 32'(rsp_err), 32'(ee));
            end
        end
    end

    // Driver: present one request at a negedge and record its expectation.
    task automatic drive(input logic wr, input logic [ADDR_W-1:0] a, input logic [2:0] nb,
                         input logic [31:0] wd, input logic [31:0] ed, input logic ee,
                         input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = wd;
        q_data.push_back(ed); q_err.push_back(ee); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic ee, input string tag);
        drive(1'b1, a, 3'd4, d, 32'h0, ee, tag);
        idle();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] ed, input logic ee, input string tag);
        drive(1'b0, a, 3'd4, 32'h0, ed, ee, tag);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check("R1 sticky reset", 32'(err_sticky), 32'd0);
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        rd(A_CTRL,   32'h0000_0A09, 1'b0, "R1 ctrl");
        rd(A_EECD,   32'h0000_2010, 1'b0, "R1 eecd");
        rd(A_PBA,    32'h0010_0030, 1'b0, "R1 pba");
        rd(A_STATUS, 32'h0, 1'b0, "R1 status");
        rd(A_MANC,   32'h0, 1'b0, "R1 manc");
        rd(A_IMC,    32'h0, 1'b0, "R1 imc");

        // R3 plain registers
        wr(A_RCTL, 32'hDEAD_BEEF, 1'b0, "R3 wr rctl");
        wr(A_TCTL, 32'h1234_5678, 1'b0, "R3 wr tctl");
        wr(A_ICR,  32'hA5A5_0F0F, 1'b0, "R3 wr icr");
        wr(A_EERD, 32'h8000_0001, 1'b0, "R3 wr eerd");
        rd(A_RCTL, 32'hDEAD_BEEF, 1'b0, "R3 rctl");
        rd(A_TCTL, 32'h1234_5678, 1'b0, "R3 tctl");
        rd(A_ICR,  32'hA5A5_0F0F, 1'b0, "R3 icr");
        rd(A_EERD, 32'h8000_0001, 1'b0, "R3 eerd");

        // R4 buffer allocation
        wr(A_PBA, 32'h0000_0020, 1'b0, "R4 wr 20");
        rd(A_PBA, 32'h0020_0020, 1'b0, "R4 share 20");
        wr(A_PBA, 32'hFFFF_0040, 1'b0, "R4 wr 40");
        rd(A_PBA, 32'h0000_0040, 1'b0, "R4 share 40");
        wr(A_PBA, 32'h0000_0050, 1'b0, "R4 wr 50");
        rd(A_PBA, 32'hFFF0_0050, 1'b0, "R4 share 50 wraps");

        // R5 grant follows request
        wr(A_EECD, 32'h0000_0040, 1'b0, "R5 wr req");
        check("R5 ee_req", 32'(ee_req), 32'd1);
        check("R5 ee_gnt", 32'(ee_gnt), 32'd1);
        rd(A_EECD, 32'h0000_00C0, 1'b0, "R5 eecd req+gnt");
        wr(A_EECD, 32'h0000_0080, 1'b0, "R5 wr gnt only");
        check("R5 ee_gnt dropped", 32'(ee_gnt), 32'd0);
        rd(A_EECD, 32'h0000_0000, 1'b0, "R5 eecd gnt only");
        wr(A_EECD, 32'h0000_0005, 1'b0, "R5 wr clk din");
        check("R5 ee_clk", 32'(ee_clk), 32'd1);
        check("R5 ee_din", 32'(ee_din), 32'd1);

        // R6 live data-out
        ee_dout = 1'b1;
        rd(A_EECD, 32'h0000_000D, 1'b0, "R6 dout high");
        ee_dout = 1'b0;
        wr(A_EECD, 32'h0000_0008, 1'b0, "R6 wr dout bit");
        rd(A_EECD, 32'h0000_0000, 1'b0, "R6 dout write ignored");

        // R7 null registers
        wr(A_WUC, 32'hFFFF_FFFF, 1'b0, "R7 wr wuc");
        rd(A_WUC, 32'h0, 1'b0, "R7 wuc");
        wr(A_LED, 32'h1234_0000, 1'b0, "R7 wr led");
        rd(A_LED, 32'h0, 1'b0, "R7 led");

        // R8 table ranges
        wr(17'h05204, 32'hFFFF_FFFF, 1'b0, "R8 wr mct");
        rd(17'h05204, 32'h0, 1'b0, "R8 mct");
        rd(17'h0547C, 32'h0, 1'b0, "R8 rxa last");
        rd(17'h057FC, 32'h0, 1'b0, "R8 vlf last");
        rd(A_CTRL, 32'h0000_0A09, 1'b0, "R8 ctrl untouched");
        check("R8 no sticky", 32'(err_sticky), 32'd0);

        // R9 unknown addresses
        wr(17'h05480, 32'hFFFF_FFFF, 1'b1, "R9 wr past rxa");
        check("R9 sticky set", 32'(err_sticky), 32'd1);
        rd(17'h03000, 32'h0, 1'b1, "R9 rd unknown");
        rd(A_MANC, 32'h0, 1'b0, "R9 good after err");
        check("R9 sticky holds", 32'(err_sticky), 32'd1);

        // R2 bad size
        drive(1'b1, A_CTRL, 3'd2, 32'h0, 32'h0, 1'b1, "R2 wr half");
        idle();
        drive(1'b0, A_CTRL, 3'd1, 32'h0, 32'h0, 1'b1, "R2 rd byte");
        idle();
        rd(A_CTRL, 32'h0000_0A09, 1'b0, "R2 ctrl untouched");

        // R10 back-to-back
        drive(1'b1, A_STATUS, 3'd4, 32'h0000_00FF, 32'h0, 1'b0, "R10 b2b wr");
        drive(1'b0, A_STATUS, 3'd4, 32'h0, 32'h0000_00FF, 1'b0, "R10 b2b rd");
        drive(1'b0, A_RCTL, 3'd4, 32'h0, 32'hDEAD_BEEF, 1'b0, "R10 b2b rd2");
        idle();
        check("R10 idle no rsp", 32'(rsp_valid), 32'd0);
        check("R10 queue drained", 32'(q_data.size()), 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule